// File: doc/BRIEF.md
# Approximate 8x8 Compressor-Tree Multiplier

This block multiplies two 8-bit unsigned operands and returns a 16-bit product that may fall slightly short of the exact value. It forms the full AND array of partial products and reduces the columns with four-input approximate compressors. Each compressor returns one sum bit in its own column and one carry bit in the next column. No carry enters or leaves a compressor sideways. The compressors are used in every column where at least four bits remain, including the most significant ones. Where a column has exactly three bits left, an exact full adder reduces it. One or two leftover bits pass through to the next stage unchanged. When every column holds at most two bits, an exact ripple adder sums the two rows.

The compressor is wrong for only one input pattern: all four inputs at one. In that case it reports a count of three instead of four. Every other pattern gives the exact count. Because of this, the product can only be too small, never too large. The block is purely combinational and has no clock or reset. It suits error-tolerant arithmetic such as neural-network inference, where a rare small shortfall is acceptable in exchange for a shallower tree built from NAND and NOR gates.

Top module: `apxmul_top`

## Requirements
- R1: The block is combinational. `p` follows `a` and `b` with no clock, and when either operand is zero, `p` is zero.
- R2: For every compressor input pattern except all ones, carry is 1 exactly when two or more inputs are 1, and sum equals the parity of the four inputs. So 2*carry+sum equals the number of ones.
- R3: For the input pattern 4'b1111, the compressor outputs carry=1 and sum=1, a count of 3 instead of 4.
- R4: When either operand has at most one bit set, `p` equals the exact product a*b.
- R5: For every operand pair, `p` is less than or equal to the exact product a*b. The shortfall comes only from compressors that met the all-ones pattern.
- R6: Approximation reaches the product. Over all 65,536 operand pairs, the share of pairs with `p` different from a*b is greater than 1% and below 40%.
- R7: Over all operand pairs with a nonzero exact product, the mean of |a*b - p| / (a*b) is below 3%.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 8 | Unsigned multiplicand |
| b | input | 8 | Unsigned multiplier |
| p | output | 16 | Approximate unsigned product |

## Verification
Within one evaluation, an all-ones fault can occur in a compressor of a high column while the final ripple adder carries across many positions. The shortfall the fault causes must then survive the carry propagation without any weight being lost or added. The exhaustive sweep of all operand pairs creates this case many times, for example with dense operands such as 0xFF by 0xFF. Each result is judged against the exact product: it must never be larger, and it must be exactly equal whenever one operand has at most one bit set, because then no column can fill a compressor.

// File: rtl/apxmul_pkg.sv
package apxmul_pkg;

    // two-input exclusive-or from four NAND gates
    function automatic logic nand_xor(input logic x0, input logic x1);
        logic g0, g1, g2;
        g0 = ~(x0 & x1);
        g1 = ~(x0 & g0);
        g2 = ~(x1 & g0);
        return ~(g1 & g2);
    endfunction

    // approximate 4:2 compressor, returns {carry, sum}; NAND/NOR network
    function automatic logic [1:0] approx42(input logic [3:0] x);
        logic n01, n23, r01, r23, t, tb;
        logic x01, x23, par, all4, npar, nall;
        logic carry, sum;
        n01  = ~(x[0] & x[1]);
        n23  = ~(x[2] & x[3]);
        r01  = ~(x[0] | x[1]);
        r23  = ~(x[2] | x[3]);
        t    = ~(r01 | r23);
        tb   = ~(t & t);
        carry = ~(n01 & n23 & tb);
        x01  = nand_xor(x[0], x[1]);
        x23  = nand_xor(x[2], x[3]);
        par  = nand_xor(x01, x23);
        all4 = ~(n01 | n23);
        npar = ~(par & par);
        nall = ~(all4 & all4);
        sum  = ~(npar & nall);
        return {carry, sum};
    endfunction

endpackage

// File: rtl/apxmul_comp42.sv
module apxmul_comp42
    import apxmul_pkg::*;
(
    input  logic [3:0] x,
    output logic       carry,
    output logic       sum
);

    always_comb begin
        {carry, sum} = approx42(x);
        if (!$isunknown(x)) begin
            if (x != 4'hF) begin
                // R2: exact count on the fifteen regular patterns
                a_r2_exact_count: assert ((int'(carry) * 2 + int'(sum)) == $countones(x))
                    else $error("compressor count wrong for %b", x);
            end else begin
                // R3: the single faulty pattern reports three
                a_r3_fault_pattern: assert (carry && sum)
                    else $error("compressor fault pattern wrong");
            end
        end
    end

endmodule

// File: rtl/apxmul_ppgen.sv
module apxmul_ppgen #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [N*N-1:0] pp
);

    // bit i*N+j carries weight 2^(i+j)
    for (genvar i = 0; i < N; i++) begin : g_row
        for (genvar j = 0; j < N; j++) begin : g_col
            assign pp[i*N+j] = a[i] & b[j];
        end
    end

endmodule

// File: rtl/apxmul_reduce.sv
module apxmul_reduce
    import apxmul_pkg::*;
#(
    parameter int N = 8
) (
    input  logic [N*N-1:0] pp,
    output logic [2*N-1:0] row0,
    output logic [2*N-1:0] row1
);

    localparam int W   = 2 * N;
    localparam int H   = N + 2;
    localparam int STG = N;
    localparam int ACC = W + 2;
    localparam int GRP = H / 4 + 1;

    logic [H-1:0]   col [W];
    logic [H-1:0]   nxt [W];
    int             cnt [W];
    int             ncnt[W];
    logic [ACC-1:0] init_val, fin_val, shortfall;
    logic           busy, tall;
    logic [3:0]     grp;
    logic [2:0]     trio;
    logic [1:0]     cs;
    logic [H-1:0]   sh;
    int             k, r;

    always_comb begin
        init_val  = '0;
        shortfall = '0;
        for (int c = 0; c < W; c++) begin
            col[c] = '0;
            cnt[c] = 0;
            nxt[c] = '0;
            ncnt[c] = 0;
        end
        grp = '0; trio = '0; cs = '0; sh = '0; k = 0; r = 0; busy = 1'b0;
        for (int i = 0; i < N; i++) begin
            for (int j = 0; j < N; j++) begin
                col[i+j] = col[i+j] | (H'(pp[i*N+j]) << cnt[i+j]);
                cnt[i+j] = cnt[i+j] + 1;
                init_val = init_val + (ACC'(pp[i*N+j]) << (i + j));
            end
        end
        for (int st = 0; st < STG; st++) begin
            busy = 1'b0;
            for (int c = 0; c < W; c++) begin
                if (cnt[c] > 2) busy = 1'b1;
            end
            if (busy) begin
                for (int c = 0; c < W; c++) begin
                    nxt[c] = '0;
                    ncnt[c] = 0;
                end
                for (int c = 0; c < W; c++) begin
                    k = 0;
                    for (int g = 0; g < GRP; g++) begin
                        if (cnt[c] - k >= 4) begin
                            grp = 4'(col[c] >> k);
                            cs  = approx42(grp);
                            if (grp == 4'hF) shortfall = shortfall + (ACC'(1) << c);
                            nxt[c] = nxt[c] | (H'(cs[0]) << ncnt[c]);
                            ncnt[c] = ncnt[c] + 1;
                            if (c + 1 < W) begin
                                nxt[c+1] = nxt[c+1] | (H'(cs[1]) << ncnt[c+1]);
                                ncnt[c+1] = ncnt[c+1] + 1;
                            end
                            k = k + 4;
                        end
                    end
                    r = cnt[c] - k;
                    if (r == 3) begin
                        trio = 3'(col[c] >> k);
                        nxt[c] = nxt[c] | (H'(^trio) << ncnt[c]);
                        ncnt[c] = ncnt[c] + 1;
                        if (c + 1 < W) begin
                            nxt[c+1] = nxt[c+1]
                                | (H'((trio[0] & trio[1]) | (trio[2] & (trio[0] | trio[1]))) << ncnt[c+1]);
                            ncnt[c+1] = ncnt[c+1] + 1;
                        end
                    end else begin
                        for (int q = 0; q < 2; q++) begin
                            if (q < r) begin
                                sh = col[c] >> (k + q);
                                nxt[c] = nxt[c] | (H'(sh[0]) << ncnt[c]);
                                ncnt[c] = ncnt[c] + 1;
                            end
                        end
                    end
                end
                for (int c = 0; c < W; c++) begin
                    col[c] = nxt[c];
                    cnt[c] = ncnt[c];
                end
            end
        end
        tall = 1'b0;
        for (int c = 0; c < W; c++) begin
            row0[c] = col[c][0];
            row1[c] = col[c][1];
            if (cnt[c] > 2) tall = 1'b1;
        end
        fin_val = ACC'(row0) + ACC'(row1);
        if (!$isunknown(pp)) begin
            // R5: the tree ends with no column above two bits
            a_r5_two_rows_left: assert (!tall)
                else $error("reduction did not converge");
            // R5: the rows never exceed the exact weighted sum
            a_r5_never_above: assert (fin_val <= init_val)
                else $error("rows above exact product");
            // R5: every unit of shortfall traces to an all-ones compressor
            a_r5_shortfall_from_faults: assert ((init_val - fin_val) == shortfall)
                else $error("shortfall not explained by faults");
        end
    end

endmodule

// File: rtl/apxmul_ripple.sv
module apxmul_ripple #(
    parameter int W = 16
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    output logic [W-1:0] s
);

    logic cy;

    always_comb begin
        cy = 1'b0;
        for (int i = 0; i < W; i++) begin
            s[i] = x[i] ^ y[i] ^ cy;
            cy   = (x[i] & y[i]) | (cy & (x[i] ^ y[i]));
        end
        if (!$isunknown({x, y})) begin
            // R5: the final two-row addition loses no weight
            a_r5_adder_exact: assert ({cy, s} == ((W+1)'(x) + (W+1)'(y)))
                else $error("final adder wrong");
        end
    end

endmodule

// File: rtl/apxmul_top.sv
module apxmul_top #(
    parameter int N = 8
) (
    input  logic [N-1:0]   a,
    input  logic [N-1:0]   b,
    output logic [2*N-1:0] p
);

    localparam int W = 2 * N;

    logic [N*N-1:0] pp;
    logic [W-1:0]   row0, row1;

    apxmul_ppgen #(.N(N)) u_ppgen (
        .a  (a),
        .b  (b),
        .pp (pp)
    );

    apxmul_reduce #(.N(N)) u_reduce (
        .pp   (pp),
        .row0 (row0),
        .row1 (row1)
    );

    apxmul_ripple #(.W(W)) u_ripple (
        .x (row0),
        .y (row1),
        .s (p)
    );

endmodule

// File: tb/apxmul_top_test.sv
module apxmul_top_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  a = '0;
    logic [7:0]  b = '0;
    logic [15:0] p;
    logic [3:0]  cx = '0;
    logic        c_carry, c_sum;

    int  checks = 0;
    int  fails  = 0;
    bit  done   = 1'b0;

    always #2 clk = ~clk;

    apxmul_top uut (.a(a), .b(b), .p(p));
    apxmul_comp42 u_cmp (.x(cx), .carry(c_carry), .sum(c_sum));

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    initial begin
        int   wrong;
        int   nz;
        int   exact;
        int   ones;
        real  red_sum;
        real  er;
        real  mred;
        wrong = 0; nz = 0; red_sum = 0.0;
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: inputs at zero after reset give a zero product
        check(p == 16'd0, "R1", int'(p), 0);

        // compressor in isolation
        for (int v = 0; v < 16; v++) begin
            @(posedge clk);
            cx = 4'(v);
            @(negedge clk);
            ones = $countones(4'(v));
            if (v == 15) begin
                check(c_carry && c_sum, "R3", int'({c_carry, c_sum}), 3);
            end else begin
                check(c_carry == (ones >= 2), "R2 carry", int'(c_carry), int'(ones >= 2));
                check(c_sum == ones[0], "R2 sum", int'(c_sum), int'(ones[0]));
            end
        end

        // exhaustive operand sweep against the exact product
        for (int ia = 0; ia < 256; ia++) begin
            for (int ib = 0; ib < 256; ib++) begin
                @(posedge clk);
                a = 8'(ia);
                b = 8'(ib);
                @(negedge clk);
                exact = ia * ib;
                check(int'(p) <= exact, "R5", int'(p), exact);
                if (ia == 0 || ib == 0)
                    check(p == 16'd0, "R1", int'(p), 0);
                else if ($countones(a) <= 1 || $countones(b) <= 1)
                    check(int'(p) == exact, "R4", int'(p), exact);
                if (int'(p) != exact) wrong++;
                if (exact != 0) begin
                    nz++;
                    red_sum = red_sum + (real'(exact - int'(p)) / real'(exact));
                end
            end
        end

        er   = 100.0 * real'(wrong) / 65536.0;
        mred = 100.0 * red_sum / real'(nz);
        $display("error rate %f %%, mean relative error distance %f %%", er, mred);
        // R6: approximation visible but rare
        check(er > 1.0 && er < 40.0, "R6", wrong, 0);
        // R7: mean relative error small
        check(mred < 3.0, "R7", int'(mred * 1000.0), 3000);

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule